// File: doc/BRIEF.md
# Station Address ROM Read Port

This block sits on the host side of a network adapter and answers a 16-byte I/O window. Two locations inside that window are live. The first is an 8-bit adapter control register. Its low four bits are writable: an LED bit, an enable for the interrupt line driver, a mask that holds the network interrupt inactive, and a counter-run bit. Its upper half reports two board straps, one for the small buffer size and one for remote-boot enable.

The second live location is a read-only byte port onto a 32-entry station-address ROM. Each read of this port returns the byte at the current position of an internal address counter and then moves that counter. When the counter-run bit is 1, the counter increments and wraps from the last entry back to zero. When the bit is 0, a read clears the counter instead. Software rewinds the counter by clearing the bit, making one dummy read of the ROM port, and setting the bit again.

The ROM contents are a placeholder table built from a linear formula.

Top module: `sar_port`

## Requirements
- R1: After reset, control bits 3:0 are 0 and the address counter is 0, so the first ROM-port read returns ROM entry 0.
- R2: A read of the control register (offset 0x0) returns these fields: bits 7:6 as 0, bit 5 as the small-buffer strap, bit 4 as the remote-boot strap, and bits 3:0 as the stored control bits.
- R3: A write to offset 0x0 stores write-data bits 3:0 (bit 0 LED, bit 1 interrupt-line enable, bit 2 interrupt mask, bit 3 counter run). Write-data bits 7:4 have no effect.
- R4: With control bit 3 set to 1, a read of the ROM port (offset 0xC) returns the entry at the counter and then increments the counter by one.
- R5: With control bit 3 set to 1, the read that follows the read of entry 31 returns entry 0, so the counter wraps after 32 reads.
- R6: With control bit 3 set to 0, a ROM-port read returns the entry at the counter and clears the counter to 0. The clear-then-set sequence therefore restarts reading at entry 0.
- R7: Writes to the ROM port change neither the counter nor the control register.
- R8: Reads of any offset other than 0x0 and 0xC return 0. Writes to those offsets change no state.
- R9: `led_out` equals control bit 0 and `irq_oe` equals control bit 1. `irq_out` equals `net_irq_req` while control bit 2 is 0, and is 0 while control bit 2 is 1.
- R10: ROM entry i holds (i*29 + 0x5A) mod 256.
- R11: Whenever `bus_sel` is 0, `bus_rdata` is 0, and a read or write strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Select for the 16-byte window |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| strap_small_buf | input | 1 | Buffer-size strap (1 means small buffer) |
| strap_rboot_en | input | 1 | Remote-boot enable strap |
| net_irq_req | input | 1 | Network interrupt request |
| irq_out | output | 1 | Network interrupt after the mask |
| irq_oe | output | 1 | Output enable for the interrupt line driver |
| led_out | output | 1 | LED drive |

## Verification
The assertions assume that every cycle with `bus_rd` high is one complete read, so holding the strobe for several cycles means several reads. They also assume that the strap inputs stay steady while the control register is being read. The stimulus raises each strobe for exactly one clock, and it changes the straps and the interrupt request only between accesses. Read data is taken in the same cycle as the strobe, before the edge that advances the counter.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned CTL_W     = 4;
  localparam int unsigned CTL_LED   = 0;
  localparam int unsigned CTL_IRQOE = 1;
  localparam int unsigned CTL_MASK  = 2;
  localparam int unsigned CTL_RUN   = 3;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_ROM  = 2'd2
  } tgt_e;

  function automatic logic [7:0] rom_byte(int unsigned idx, int unsigned mul,
                                          int unsigned seed);
    return 8'((idx * mul + seed) % 256);
  endfunction

endpackage

// File: rtl/sar_decode.sv
module sar_decode #(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] ROM_OFS  = ADDR_W'(12)
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output sar_pkg::tgt_e     tgt
);

  always_comb begin
    tgt = sar_pkg::TGT_NONE;
    if (sel) begin
      if (addr == CTRL_OFS)     tgt = sar_pkg::TGT_CTRL;
      else if (addr == ROM_OFS) tgt = sar_pkg::TGT_ROM;
    end
  end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [sar_pkg::CTL_W-1:0] wdata,
  input  logic                     strap_small,
  input  logic                     strap_rboot,
  output logic [sar_pkg::CTL_W-1:0] ctl_q,
  output logic [DATA_W-1:0]        rd_val
);

  localparam int unsigned PAD_W = DATA_W - sar_pkg::CTL_W - 2;

  logic [sar_pkg::CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign rd_val = {{PAD_W{1'b0}}, strap_small, strap_rboot, ctl_q};

endmodule

// File: rtl/sar_romport.sv
module sar_romport #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned MUL   = 29,
  parameter int unsigned SEED  = 90,
  localparam int unsigned CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             run,
  output logic [7:0]       data,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  logic [7:0]       rom_tbl [DEPTH];
  logic [CNT_W-1:0] cnt_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom_tbl[g] = sar_pkg::rom_byte(g, MUL, SEED);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (rd_en) begin
      if (!run)               cnt_d = '0;
      else if (cnt_q == LAST) cnt_d = '0;
      else                    cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (rd_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign data = rom_tbl[cnt_q];

endmodule

// File: rtl/sar_port.sv
module sar_port #(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = '0,
  parameter logic [ADDR_W-1:0] ROM_OFS   = ADDR_W'(12),
  parameter int unsigned       ROM_DEPTH = 32,
  parameter int unsigned       ROM_MUL   = 29,
  parameter int unsigned       ROM_SEED  = 90,
  localparam int unsigned      CNT_W     = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              strap_small_buf,
  input  logic              strap_rboot_en,
  input  logic              net_irq_req,
  output logic              irq_out,
  output logic              irq_oe,
  output logic              led_out
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sar_pkg::tgt_e             tgt;
  logic                      ctrl_wr;
  logic                      rom_rd;
  logic [sar_pkg::CTL_W-1:0] ctl;
  logic [7:0]                ctrl_val;
  logic [7:0]                rom_val;
  logic [CNT_W-1:0]          cnt;
  logic                      wdata_hi_unused;

  assign wdata_hi_unused = ^bus_wdata[7:sar_pkg::CTL_W];

  sar_decode #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .ROM_OFS (ROM_OFS)
  ) dec_i (
    .sel (bus_sel),
    .addr(bus_addr),
    .tgt (tgt)
  );

  assign ctrl_wr = (tgt == sar_pkg::TGT_CTRL) && bus_wr;
  assign rom_rd  = (tgt == sar_pkg::TGT_ROM) && bus_rd;

  sar_ctrl #(.DATA_W(8)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (ctrl_wr),
    .wdata      (bus_wdata[sar_pkg::CTL_W-1:0]),
    .strap_small(strap_small_buf),
    .strap_rboot(strap_rboot_en),
    .ctl_q      (ctl),
    .rd_val     (ctrl_val)
  );

  sar_romport #(
    .DEPTH(ROM_DEPTH),
    .MUL  (ROM_MUL),
    .SEED (ROM_SEED)
  ) rom_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .rd_en(rom_rd),
    .run  (ctl[sar_pkg::CTL_RUN]),
    .data (rom_val),
    .cnt_q(cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (tgt)
        sar_pkg::TGT_CTRL: bus_rdata = ctrl_val;
        sar_pkg::TGT_ROM:  bus_rdata = rom_val;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign led_out = ctl[sar_pkg::CTL_LED];
  assign irq_oe  = ctl[sar_pkg::CTL_IRQOE];
  assign irq_out = net_irq_req & ~ctl[sar_pkg::CTL_MASK];

endmodule

// File: rtl/sar_port_chk.sv
module sar_port_chk #(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter int unsigned       DEPTH    = 32,
  localparam int unsigned      CNT_W    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_rd,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              wmask,
  input logic [7:0]        bus_rdata,
  input logic              strap_small,
  input logic              strap_rboot,
  input logic              irq_out
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  p_ctrl_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == CTRL_OFS) |->
      (bus_rdata[7:6] == 2'b00 && bus_rdata[5] == strap_small &&
       bus_rdata[4] == strap_rboot));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && run && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && run && cnt == LAST) |=> (cnt == '0));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && !run) |=> (cnt == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_rd |=> $stable(cnt));

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == CTRL_OFS && wmask) |=> !irq_out);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == 8'h00));

endmodule

bind sar_port sar_port_chk #(
  .ADDR_W  (ADDR_W),
  .CTRL_OFS(CTRL_OFS),
  .DEPTH   (ROM_DEPTH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rom_rd     (rom_rd),
  .run        (ctl[sar_pkg::CTL_RUN]),
  .cnt        (cnt),
  .bus_sel    (bus_sel),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .wmask      (bus_wdata[sar_pkg::CTL_MASK]),
  .bus_rdata  (bus_rdata),
  .strap_small(strap_small_buf),
  .strap_rboot(strap_rboot_en),
  .irq_out    (irq_out)
);

// File: tb/sar_port_tb.sv
`timescale 1ns/1ps
module sar_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       strap_small_buf = 1'b1;
  logic       strap_rboot_en = 1'b0;
  logic       net_irq_req = 1'b1;
  logic       irq_out, irq_oe, led_out;

  int n_checks = 0;
  int n_errors = 0;
  int exp_cnt  = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  sar_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .strap_small_buf(strap_small_buf),
    .strap_rboot_en(strap_rboot_en), .net_irq_req(net_irq_req),
    .irq_out(irq_out), .irq_oe(irq_oe), .led_out(led_out)
  );

  function automatic logic [7:0] exp_rom(int i);
    return 8'((((i % 32) * 29) + 90) % 256);
  endfunction

  function automatic logic [7:0] exp_ctrl(logic [3:0] c);
    return {2'b00, strap_small_buf, strap_rboot_en, c};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_write(logic sel, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(logic sel, logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rom_read_chk(string req, logic run);
    do_read(1'b1, 4'hC, rv);
    chk(req, rv, exp_rom(exp_cnt));
    exp_cnt = run ? (exp_cnt + 1) % 32 : 0;
  endtask

  initial begin
    #500000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R9: reset state
    chk("R1 led", {7'b0, led_out}, 8'h00);
    chk("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
    chk("R9 irq passes", {7'b0, irq_out}, 8'h01);
    do_read(1'b1, 4'h0, rv);
    chk("R1 R2 ctrl after reset", rv, exp_ctrl(4'h0));
    rom_read_chk("R1 first rom byte", 1'b0);

    // R2: strap sweep
    for (int s = 0; s < 4; s++) begin
      strap_small_buf = s[1]; strap_rboot_en = s[0];
      do_read(1'b1, 4'h0, rv);
      chk("R2 strap fields", rv, exp_ctrl(4'h0));
    end

    // R3 / R9: full control write sweep
    for (int v = 0; v < 256; v++) begin
      net_irq_req = v[5];
      do_write(1'b1, 4'h0, 8'(v));
      do_read(1'b1, 4'h0, rv);
      chk("R3 ctrl readback", rv, exp_ctrl(4'(v)));
      chk("R9 led", {7'b0, led_out}, {7'b0, v[0]});
      chk("R9 irq_oe", {7'b0, irq_oe}, {7'b0, v[1]});
      chk("R9 irq mask", {7'b0, irq_out}, {7'b0, v[5] & ~v[2]});
    end

    // R4 / R5 / R10: run mode, more than two passes
    do_write(1'b1, 4'h0, 8'h08);
    for (int i = 0; i < 70; i++) begin
      if (exp_cnt == 0 && i > 0) rom_read_chk("R5 wrap", 1'b1);
      else rom_read_chk("R4 R10 sequential", 1'b1);
    end

    // R7: rom port writes ignored
    do_write(1'b1, 4'hC, 8'hFF);
    do_read(1'b1, 4'h0, rv);
    chk("R7 ctrl untouched", rv, exp_ctrl(4'h8));
    rom_read_chk("R7 counter untouched", 1'b1);

    // R8: other offsets
    for (int a = 1; a < 16; a++) begin
      if (a != 12) begin
        do_write(1'b1, 4'(a), 8'hF7);
        do_read(1'b1, 4'(a), rv);
        chk("R8 unused offset", rv, 8'h00);
      end
    end
    do_read(1'b1, 4'h0, rv);
    chk("R8 ctrl unchanged", rv, exp_ctrl(4'h8));
    rom_read_chk("R8 counter unchanged", 1'b1);

    // R6: clear, dummy read, set
    do_write(1'b1, 4'h0, 8'h00);
    rom_read_chk("R6 dummy read data", 1'b0);
    rom_read_chk("R6 held at zero", 1'b0);
    do_write(1'b1, 4'h0, 8'h08);
    rom_read_chk("R6 restart entry 0", 1'b1);
    rom_read_chk("R6 then entry 1", 1'b1);

    // R11: unselected accesses
    do_write(1'b0, 4'h0, 8'h07);
    chk("R11 led", {7'b0, led_out}, 8'h00);
    do_read(1'b0, 4'hC, rv);
    chk("R11 idle rdata", rv, 8'h00);
    do_read(1'b1, 4'h0, rv);
    chk("R11 ctrl unchanged", rv, exp_ctrl(4'h8));
    rom_read_chk("R11 counter unchanged", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule